// File: doc/BRIEF.md
# Four-State Strap Pin Decoder

This block decodes two board-level configuration straps into link-mode defaults. Each strap can be tied high, tied low, left floating, or driven by a free-running clock. Each strap reaches the block through two comparator outputs. One comparator has its threshold above mid-supply and the other has its threshold below it. A strap that sits at a steady level shows up as a steady pair of readings. A clocked strap shows up as a pair that keeps toggling.

After hardware reset is released, the block synchronises the comparator bits and counts their transitions over a fixed observation window. When the window closes, it latches one 2-bit state per strap. It then turns the pair of states into default bits for the link-mode controller: one negotiation-enable bit, one duplex bit, one speed bit and four ability bits. A done flag marks the moment these values become valid. The values then hold until the next hardware reset, whatever the straps do afterwards.

Top module: `strap_pin_decoder`

## Requirements
- R1: While reset is asserted, and until done rises, `done` is 0 and `pin_code` and `dflt_bits` are all zero.
- R2: Counting the first rising clock edge after reset release as edge 1, `done` is still 0 after edge WIN and becomes 1 at edge WIN+1. It then stays 1 until reset.
- R3: Each strap gets a state code: 2'b00 for low (both comparators read 0), 2'b01 for high (both read 1), 2'b10 for floating (the readings disagree) and 2'b11 for clocked. Strap 0 sits in `pin_code[1:0]` and strap 1 in `pin_code[3:2]`. Both comparator inputs pass through a two-flop synchroniser before any use. Levels are taken from the synchronised value present at edge WIN+1.
- R4: A strap is coded clocked only when each of its two synchronised comparator bits changes at least TOG_MIN times within the window. With exactly TOG_MIN changes it is clocked. With TOG_MIN-1 changes, or when only one comparator toggles, it is classified by its levels.
- R5: Once `done` is 1, changes on the comparator inputs have no effect on `pin_code`, `dflt_bits` or `done`.
- R6: `dflt_bits` holds {neg_enable[6], full_duplex[5], speed_100[4], ability[3:0]}. The ability bits are [3]=100 full, [2]=100 half, [1]=10 full and [0]=10 half. When both straps float, the value is 7'h7F.
- R7: When exactly one strap floats, negotiation is enabled and the other strap's state picks the abilities: low gives 4'b0011, high gives 4'b1100, clocked gives 4'b0101.
- R8: When neither strap floats, negotiation is off and exactly one ability bit is set. Strap 0 chooses duplex (low gives half, high or clocked gives full). Strap 1 chooses speed (low gives 10, high or clocked gives 100).
- R9: `full_duplex` and `speed_100` describe the highest-priority ability that is set, using the order 100 full, 100 half, 10 full, 10 half.
- R10: Asserting reset part-way through the window discards the partial observation. The next window starts over at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmp_hi | input | 2 | Upper-threshold comparator output, one bit per strap |
| cmp_lo | input | 2 | Lower-threshold comparator output, one bit per strap |
| pin_code | output | 4 | Latched strap states, strap 1 in the upper pair |
| dflt_bits | output | 7 | Default negotiation, duplex, speed and ability bits |
| done | output | 1 | Decoded values are valid |

## Verification
The hardest cases to reach from the ports are the ones near the toggle threshold.

- **Exact threshold.** The stimulus is indexed by the edge count since reset release. A strap is made to change exactly TOG_MIN times, and in another run TOG_MIN-1 times, inside the window. The changes are placed so that the two-cycle synchroniser delay still lands every one of them in the counted span.
- **One comparator toggling.** A separate pattern toggles only the upper comparator. This must fall back to a floating code rather than clocked.
- **Mid-window reset.** Another sequence asserts reset mid-window, changes the straps, and confirms that only the second window counts.

A behavioural model follows every cycle of all these runs.

// File: rtl/strap_pin_decoder.sv
module strap_pin_decoder #(
  parameter int WIN     = 64,
  parameter int TOG_MIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmp_hi,
  input  logic [1:0] cmp_lo,
  output logic [3:0] pin_code,
  output logic [6:0] dflt_bits,
  output logic       done
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WIN);
  localparam logic [CW-1:0] TOG_L = CW'(TOG_MIN);
  localparam logic [1:0] S_LOW = 2'b00, S_HIGH = 2'b01, S_FLT = 2'b10, S_CLK = 2'b11;

  logic [3:0] sy1, sy2, sy3;
  logic [CW-1:0] win_cnt;
  logic [CW-1:0] tog [4];
  logic [3:0] code_nxt;
  logic [6:0] map_nxt;
  logic       last;

  assign last = (win_cnt == WIN_L);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= {cmp_lo, cmp_hi};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_tog
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tog[g] <= '0;
        else if (!done && !last && (sy2[g] != sy3[g])) tog[g] <= tog[g] + CW'(1);
    end
    for (g = 0; g < 2; g++) begin : g_cls
      logic hi, lo, clkd;
      assign hi   = sy2[g];
      assign lo   = sy2[2+g];
      assign clkd = (tog[g] >= TOG_L) && (tog[2+g] >= TOG_L);
      assign code_nxt[2*g+1:2*g] = clkd ? S_CLK : (hi && lo) ? S_HIGH :
                                   (!hi && !lo) ? S_LOW : S_FLT;
    end
  endgenerate

  always_comb begin
    logic [1:0] c0, c1, oth;
    logic [3:0] adv;
    logic an, dup, spd;
    c0 = code_nxt[1:0];
    c1 = code_nxt[3:2];
    oth = (c0 == S_FLT) ? c1 : c0;
    if (c0 == S_FLT && c1 == S_FLT) begin
      an = 1'b1; adv = 4'b1111;
    end else if (c0 == S_FLT || c1 == S_FLT) begin
      an = 1'b1;
      case (oth)
        S_LOW:   adv = 4'b0011;
        S_HIGH:  adv = 4'b1100;
        default: adv = 4'b0101;
      endcase
    end else begin
      an  = 1'b0;
      adv = 4'b0001 << {c1 != S_LOW, c0 != S_LOW};
    end
    if (adv[3])      {dup, spd} = 2'b11;
    else if (adv[2]) {dup, spd} = 2'b01;
    else if (adv[1]) {dup, spd} = 2'b10;
    else             {dup, spd} = 2'b00;
    map_nxt = {an, dup, spd, adv};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0; done <= 1'b0; pin_code <= '0; dflt_bits <= '0;
    end else if (!done) begin
      if (last) begin
        done      <= 1'b1;
        pin_code  <= code_nxt;
        dflt_bits <= map_nxt;
      end else begin
        win_cnt <= win_cnt + CW'(1);
      end
    end
endmodule

module strap_pin_decoder_chk #(
  parameter int WIN = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] pin_code,
  input logic [6:0] dflt_bits,
  input logic       done
);
  logic [31:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (!done) cyc <= cyc + 32'd1;

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (pin_code == 4'd0 && dflt_bits == 7'd0));
  // R2
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cyc == 32'(WIN + 1));
  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(pin_code) && $stable(dflt_bits)));
  // R6
  both_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pin_code == 4'b1010) |-> dflt_bits == 7'h7F);
  // R8
  forced_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dflt_bits[6]) |-> $countones(dflt_bits[3:0]) == 1);
  // R9
  top_ability_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dflt_bits[3]) |-> (dflt_bits[5] && dflt_bits[4]));
endmodule

bind strap_pin_decoder strap_pin_decoder_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .dflt_bits(dflt_bits), .done(done)
);

// File: tb/sim_strap_pin_decoder.sv
module sim_strap_pin_decoder;
  localparam int WIN = 64, TOG = 8;
  localparam int P_LOW = 0, P_HIGH = 1, P_FLT = 2, P_CLK = 3, P_T8 = 4, P_T7 = 5, P_ONEHI = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] cmp_hi = '0, cmp_lo = '0;
  logic [3:0] pin_code;
  logic [6:0] dflt_bits;
  logic done;
  int total = 0, bad = 0, ecyc = 0, mode0 = P_LOW, mode1 = P_LOW;
  bit finished = 0;

  strap_pin_decoder #(.WIN(WIN), .TOG_MIN(TOG)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic seg(int k, int n, logic fin);
    if (k < 10) return 1'b0;
    if (k < 10 + n) return ((k - 10) % 2) == 0;
    return fin;
  endfunction

  function automatic logic hv(int m, int k);
    case (m)
      P_HIGH:  return 1'b1;
      P_CLK:   return ((k / 2) % 2) == 1;
      P_T8:    return seg(k, 8, 1'b0);
      P_T7:    return seg(k, 7, 1'b1);
      P_ONEHI: return (k < 40) ? ((k % 2) == 1) : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic lv(int m, int k);
    if (m == P_FLT || m == P_ONEHI) return 1'b1;
    return hv(m, k);
  endfunction

  always @(negedge clk) begin
    #1;
    cmp_hi = {hv(mode1, ecyc + 1), hv(mode0, ecyc + 1)};
    cmp_lo = {lv(mode1, ecyc + 1), lv(mode0, ecyc + 1)};
  end

  function automatic logic [6:0] ref_map(logic [1:0] a, logic [1:0] b);
    logic [3:0] ab;
    logic en;
    logic [1:0] other;
    en = 1'b1;
    if (a == 2'b10 && b == 2'b10) ab = 4'hF;
    else if (a == 2'b10 || b == 2'b10) begin
      other = (a == 2'b10) ? b : a;
      ab = (other == 2'b00) ? 4'b0011 : (other == 2'b01) ? 4'b1100 : 4'b0101;
    end else begin
      en = 1'b0;
      ab = '0;
      ab[((b == 2'b00) ? 0 : 2) + ((a == 2'b00) ? 0 : 1)] = 1'b1;
    end
    for (int p = 3; p >= 0; p--)
      if (ab[p]) return {en, p[0] == 1'b1, p >= 2, ab};
    return {en, 2'b00, ab};
  endfunction

  logic [3:0] hist[$];
  logic m_done = 0;
  logic [3:0] m_code = '0;
  logic [6:0] m_dflt = '0;

  function automatic logic [3:0] inp(int n);
    return (n >= 1) ? hist[n-1] : 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ecyc = 0; hist.delete(); m_done = 0; m_code = '0; m_dflt = '0;
    end else begin
      ecyc++;
      if (!m_done) begin
        hist.push_back({cmp_lo, cmp_hi});
        if (hist.size() == WIN + 1) begin
          int cnt[4];
          logic [3:0] lvl;
          logic [1:0] cd[2];
          for (int c = 0; c < 4; c++) cnt[c] = 0;
          for (int n = 1; n <= WIN; n++)
            for (int c = 0; c < 4; c++)
              if (inp(n - 2)[c] != inp(n - 3)[c]) cnt[c]++;
          lvl = inp(WIN - 1);
          for (int p = 0; p < 2; p++) begin
            if (cnt[p] >= TOG && cnt[p+2] >= TOG) cd[p] = 2'b11;
            else if (lvl[p] && lvl[p+2]) cd[p] = 2'b01;
            else if (!lvl[p] && !lvl[p+2]) cd[p] = 2'b00;
            else cd[p] = 2'b10;
          end
          m_code = {cd[1], cd[0]};
          m_dflt = ref_map(cd[0], cd[1]);
          m_done = 1;
        end
      end
    end
    #2;
    if (!finished) begin
      chk(done, m_done, "R2 model done");
      chk(pin_code, m_code, "R3 model code");
      chk(dflt_bits, m_dflt, "R6 model defaults");
      if (rst_n && ecyc == WIN) chk(done, 0, "R2 done before window end");
      if (rst_n && ecyc == WIN + 1) chk(done, 1, "R2 done at window end");
    end
  end

  task automatic run(int a, int b, logic [3:0] ec, logic [6:0] ed, string req);
    @(negedge clk);
    rst_n = 0; mode0 = a; mode1 = b;
    repeat (3) @(negedge clk);
    chk(done, 0, "R1 reset done");
    chk(pin_code, 0, "R1 reset code");
    chk(dflt_bits, 0, "R1 reset defaults");
    rst_n = 1;
    repeat (WIN + 4) @(negedge clk);
    chk(pin_code, ec, req);
    chk(dflt_bits, ed, req);
  endtask

  initial begin
    run(P_LOW,  P_LOW,  4'b0000, 7'b000_0001, "R8 low/low");
    mode0 = P_CLK; mode1 = P_HIGH;
    repeat (80) @(negedge clk);
    chk(pin_code, 4'b0000, "R5 code frozen");
    chk(dflt_bits, 7'b000_0001, "R5 defaults frozen");
    chk(done, 1, "R5 done held");
    run(P_FLT,  P_FLT,  4'b1010, 7'b111_1111, "R6 both float");
    run(P_HIGH, P_HIGH, 4'b0101, 7'b011_1000, "R8 high/high");
    run(P_CLK,  P_LOW,  4'b0011, 7'b010_0010, "R8 clk/low");
    run(P_FLT,  P_HIGH, 4'b0110, 7'b111_1100, "R7 float/high");
    run(P_LOW,  P_FLT,  4'b1000, 7'b110_0011, "R7 low/float");
    run(P_FLT,  P_CLK,  4'b1110, 7'b101_0101, "R9 float/clk");
    run(P_T8,   P_T7,   4'b0111, 7'b011_1000, "R4 threshold");
    run(P_ONEHI, P_LOW, 4'b0010, 7'b110_0011, "R4 single comparator");
    run(P_HIGH, P_CLK,  4'b1101, 7'b011_1000, "R3 high/clk");
    run(P_LOW,  P_HIGH, 4'b0100, 7'b001_0100, "R9 low/high");
    @(negedge clk);
    rst_n = 0; mode0 = P_HIGH; mode1 = P_HIGH;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (30) @(negedge clk);
    rst_n = 0; mode0 = P_LOW; mode1 = P_HIGH;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (WIN) @(negedge clk);
    chk(done, 0, "R10 window restarted");
    repeat (4) @(negedge clk);
    chk(pin_code, 4'b0100, "R10 code after restart");
    chk(dflt_bits, 7'b001_0100, "R10 defaults after restart");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule